// File: doc/BRIEF.md
# Cache invalidate-all sequencer

This block clears the whole cache when software asks for it. Software writes 1 to a single control bit. The block then steps through the tag/state array one set per clock. For each set it raises a clear enable together with the set index, and the array drops the valid and modified state of every way in that set. While the walk runs, a stall output holds back the access pipeline. When the walk ends, the control bit falls back to 0 by itself and the block emits a one-cycle completion pulse. The fill buffer uses the same pulse to discard whatever noncacheable data it holds.

Reset only returns the sequencer to idle. It never starts a walk, so the cache contents survive reset. Writing dirty lines back before an invalidation is left to software.

Top module: `cache_inv_sweep`

## Requirements
- R1: After reset, stall_o, clr_en_o, done_o and ctl_rdata_o are all 0. With no write of 1, they stay 0 indefinitely, so reset never starts a sweep.
- R2: When the block is idle, a clock edge with ctl_we_i=1 and ctl_wdata_i=1 starts a sweep. In the next cycle stall_o=1, clr_en_o=1 and clr_idx_o=0.
- R3: A write with ctl_wdata_i=0 has no effect. When idle, stall_o, clr_en_o and ctl_rdata_o stay 0. During a sweep, the sweep continues unchanged.
- R4: A sweep holds clr_en_o high for exactly NUM_SETS consecutive cycles. During those cycles clr_idx_o takes the values 0, 1, …, NUM_SETS-1 in order, one set per cycle.
- R5: stall_o is high from the cycle after the start write through the cycle that clears set NUM_SETS-1. It is low in the following cycle.
- R6: ctl_rdata_o reads 1 for the whole sweep. It returns to 0 after the sweep without any software write.
- R7: A write of 1 during a sweep is ignored. The index keeps counting up and the sweep does not restart.
- R8: done_o is a single-cycle pulse in the cycle after set NUM_SETS-1 is cleared. It tells the fill buffer to drop its contents.
- R9: A write of 1 in the cycle done_o is high starts a new sweep at once, with clr_idx_o=0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control register write strobe |
| ctl_wdata_i | input | 1 | Value written to the invalidate bit |
| ctl_rdata_o | output | 1 | Readback of the invalidate bit |
| stall_o | output | 1 | Holds off cache accesses while sweeping |
| clr_en_o | output | 1 | Clears valid and modified bits of all ways in the indexed set |
| clr_idx_o | output | IDX_W | Set being cleared |
| done_o | output | 1 | Completion pulse; also discards the fill buffer |

## Verification
The bench builds two instances that share the same stimulus.

- The first uses NUM_SETS=5. Full sweeps are then short, so random writes of 1 and 0 often land at the start, in the middle, on the last set and on the done cycle of a sweep. This exercises restart rejection and back-to-back sweeps.
- The second uses NUM_SETS=1. This selects the variant with no counter, where the first set is also the last one, so the done pulse follows the start after a single clear cycle.

// File: rtl/cinv_pkg.sv
package cinv_pkg;
  typedef enum logic {SW_IDLE = 1'b0, SW_RUN = 1'b1} sweep_state_e;

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/cinv_idx_cnt.sv
module cinv_idx_cnt #(
  parameter int NUM_SETS = 128,
  parameter int IDX_W    = cinv_pkg::idx_width(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             step_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             last_o
);
  generate
    if (NUM_SETS == 1) begin : g_single
      // first set is the last set
      assign idx_o  = '0;
      assign last_o = 1'b1;
    end else begin : g_count
      logic [IDX_W-1:0] idx_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      idx_q <= '0;
        else if (clear_i) idx_q <= '0;
        else if (step_i)  idx_q <= idx_q + IDX_W'(1);
      end
      assign idx_o  = idx_q;
      assign last_o = (idx_q == IDX_W'(NUM_SETS - 1));

      AST_IDX_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step_i && !clear_i) |=> (idx_q == $past(idx_q) + IDX_W'(1))) else $error("idx step"); // R4
    end
  endgenerate

  AST_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(idx_o) < NUM_SETS) else $error("idx range"); // R4
endmodule

// File: rtl/cinv_ctrl.sv
module cinv_ctrl
  import cinv_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic last_i,
  output logic run_o,
  output logic clear_o,
  output logic step_o,
  output logic done_o
);
  sweep_state_e state_q, state_d;
  logic         done_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SW_IDLE: if (start_i) state_d = SW_RUN;
      SW_RUN:  if (last_i)  state_d = SW_IDLE;
      default: state_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SW_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= (state_q == SW_RUN) && last_i;
    end
  end

  assign run_o   = (state_q == SW_RUN);
  // starts are accepted only from idle; writes during a run are dropped
  assign clear_o = (state_q == SW_IDLE) && start_i;
  assign step_o  = run_o && !last_i;
  assign done_o  = done_q;

  AST_START_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_o && start_i) |=> run_o) else $error("start"); // R2
  AST_LAST_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && last_i) |=> (done_o && !run_o)) else $error("end"); // R5
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o) else $error("done pulse"); // R8
  AST_RUN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && !last_i) |=> run_o) else $error("run hold"); // R7
endmodule

// File: rtl/cache_inv_sweep.sv
module cache_inv_sweep #(
  parameter int NUM_SETS = 128,
  localparam int IDX_W   = cinv_pkg::idx_width(NUM_SETS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic             ctl_wdata_i,
  output logic             ctl_rdata_o,
  output logic             stall_o,
  output logic             clr_en_o,
  output logic [IDX_W-1:0] clr_idx_o,
  output logic             done_o
);
  logic start, run, clear, step, last;

  // only a write of 1 requests an invalidate
  assign start = ctl_we_i && ctl_wdata_i;

  cinv_ctrl u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start),
    .last_i  (last),
    .run_o   (run),
    .clear_o (clear),
    .step_o  (step),
    .done_o  (done_o)
  );

  cinv_idx_cnt #(.NUM_SETS(NUM_SETS), .IDX_W(IDX_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (clear),
    .step_i  (step),
    .idx_o   (clr_idx_o),
    .last_o  (last)
  );

  assign stall_o     = run;
  assign clr_en_o    = run;
  assign ctl_rdata_o = run;

  AST_FIRST_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && ctl_we_i && ctl_wdata_i) |=> (clr_en_o && clr_idx_o == '0)) else $error("first set"); // R2
  AST_ZERO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stall_o && !(ctl_we_i && ctl_wdata_i)) |=> !stall_o) else $error("idle hold"); // R3
  AST_NO_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stall_o && !last && ctl_we_i) |=> (stall_o && clr_idx_o != '0)) else $error("restart"); // R7
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!ctl_rdata_o && $past(ctl_rdata_o))) else $error("done"); // R8
endmodule

// File: tb/sim_cache_inv_sweep.sv
module sim_cache_inv_sweep;
  localparam int N0 = 5;
  localparam int N1 = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, wd = 1'b0;
  always #2 clk = ~clk;

  logic rd0, st0, ce0, dn0, rd1, st1, ce1, dn1;
  logic [2:0] ix0;
  logic [0:0] ix1;

  cache_inv_sweep #(.NUM_SETS(N0)) u0 (.clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wd),
    .ctl_rdata_o(rd0), .stall_o(st0), .clr_en_o(ce0), .clr_idx_o(ix0), .done_o(dn0));
  cache_inv_sweep #(.NUM_SETS(N1)) u1 (.clk_i(clk), .rst_ni(rst_n), .ctl_we_i(we), .ctl_wdata_i(wd),
    .ctl_rdata_o(rd1), .stall_o(st1), .clr_en_o(ce1), .clr_idx_o(ix1), .done_o(dn1));

  int errors = 0, checks = 0, cycles = 0;
  int ns [2] = '{N0, N1};
  bit m_busy [2];
  int m_idx [2];
  bit m_done [2];

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
    end
  endtask

  function automatic int o_idx(input int k);
    return (k == 0) ? int'(ix0) : int'(ix1);
  endfunction

  task automatic check_all();
    chk("R5", "u0 stall", int'(st0), int'(m_busy[0]));
    chk("R6", "u0 rdata", int'(rd0), int'(m_busy[0]));
    chk("R4", "u0 clr_en", int'(ce0), int'(m_busy[0]));
    chk("R8", "u0 done", int'(dn0), int'(m_done[0]));
    if (m_busy[0]) chk("R4", "u0 idx", o_idx(0), m_idx[0]);
    chk("R5", "u1 stall", int'(st1), int'(m_busy[1]));
    chk("R6", "u1 rdata", int'(rd1), int'(m_busy[1]));
    chk("R8", "u1 done", int'(dn1), int'(m_done[1]));
    if (m_busy[1]) chk("R4", "u1 idx", o_idx(1), m_idx[1]);
  endtask

  // one cycle: drive at negedge, update expected model across the posedge
  task automatic step(input bit w, input bit d);
    we = w; wd = d;
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      bit last = m_busy[k] && (m_idx[k] == ns[k] - 1);
      m_done[k] = last;
      if (!m_busy[k]) begin
        if (w && d) begin m_busy[k] = 1'b1; m_idx[k] = 0; end
      end else if (last) m_busy[k] = 1'b0;
      else m_idx[k]++;
    end
    @(negedge clk);
    check_all();
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++; checks++;
      $display("FAIL watchdog act=%0d exp=0", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < 2; k++) begin m_busy[k] = 0; m_idx[k] = 0; m_done[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk("R1", "reset stall", int'(st0 | st1), 0);
    chk("R1", "reset rdata", int'(rd0 | rd1), 0);
    chk("R1", "reset done", int'(dn0 | dn1), 0);
    repeat (4) step(1'b0, 1'b0);                    // R1 idle stays idle
    step(1'b1, 1'b0);                               // R3 write 0 idle
    chk("R3", "write0 stall", int'(st0), 0);
    step(1'b1, 1'b1);                               // R2 start
    chk("R2", "start stall", int'(st0), 1);
    chk("R2", "start idx", o_idx(0), 0);
    chk("R8", "u1 no done yet", int'(dn1), 0);
    step(1'b1, 1'b1);                               // R7 restart ignored
    chk("R7", "no restart idx", o_idx(0), 1);
    chk("R8", "u1 done after one set", int'(dn1), 1);
    step(1'b1, 1'b0);                               // R3 write 0 mid sweep
    chk("R3", "write0 mid idx", o_idx(0), 2);
    step(1'b0, 1'b0);
    step(1'b0, 1'b0);
    chk("R5", "last set stall", int'(st0), 1);
    step(1'b0, 1'b0);
    chk("R8", "done pulse", int'(dn0), 1);
    chk("R6", "self clear", int'(rd0), 0);
    step(1'b1, 1'b1);                               // R9 restart on done cycle
    chk("R9", "back-to-back idx", o_idx(0), 0);
    chk("R9", "back-to-back stall", int'(st0), 1);
    for (int i = 0; i < 600; i++) begin
      bit w = ($urandom % 4) == 0;
      step(w, 1'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule